// File: doc/BRIEF.md
# Timer Event Flag Register

This block holds the sixteen-bit event flag word of a timer. The counter, comparators and capture path sit outside it and send one-cycle strobes: an update from the repetition counter, a software update request, a counter restart caused by a trigger, a match or capture on each of four channels, a commutation event, a trigger event, and the level of the break input. Each strobe sets its flag in the clock edge where it is seen. The flag word goes to the interrupt logic and is also the value that a bus read returns.

Software clears flags by writing the word with a zero in each bit it wants to clear. A one in a bit leaves that bit unchanged. A channel flag also clears when the channel's capture value is read. In input capture mode, each channel has a second flag that records a capture arriving while the first flag is still set. If a hardware set and a clear reach the same bit in one cycle, the set wins.

Top module: `timer_status_flags`

## Requirements
- R1: After reset every flag reads zero. The bit layout is: bit 0 update, bits 1..4 channel 1..4 event, bit 5 commutation, bit 6 trigger, bit 7 break, bits 9..12 channel 1..4 overcapture.
- R2: A repetition over/underflow strobe sets bit 0 when updDisable is 0. It has no effect when updDisable is 1.
- R3: A software update request or a trigger-caused counter restart sets bit 0 only when updSourceSel and updDisable are both 0.
- R4: A channel event strobe sets that channel's event flag, both in output compare mode (a match) and in input capture mode (a capture).
- R5: A bus write clears each flag whose bit is written 0. Flags whose bit is written 1 keep their value.
- R6: A pulse on ccRegRead[i] clears the event flag of channel i and no other flag.
- R7: The commutation and trigger flags are set by their strobes and are cleared only by a bus write. A capture register read does not clear them.
- R8: The break flag is set while breakActive is 1, and a zero write cannot clear it then. Once breakActive is 0, the flag stays set until a zero write clears it.
- R9: In input capture mode (ccInputMode[i]=1), a capture on a channel whose event flag is already set sets that channel's overcapture flag. In output compare mode this never happens. Only a bus write clears an overcapture flag.
- R10: A hardware set in the same cycle as a write-zero clear or a capture register read leaves the flag at 1.
- R11: Bits 8 and 15..13 always read 0, even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the flag word |
| busWrData | input | 16 | Write data; a 0 bit clears that flag |
| ccRegRead | input | 4 | Per-channel capture register read strobe |
| repOvf | input | 1 | Repetition counter over/underflow strobe |
| swUpdReq | input | 1 | Software update request strobe |
| trigReinit | input | 1 | Counter restarted by a trigger |
| updDisable | input | 1 | Update generation disabled |
| updSourceSel | input | 1 | Restricts update sources to the repetition counter |
| ccEvent | input | 4 | Per-channel match or capture strobe |
| ccInputMode | input | 4 | 1 = channel in input capture mode |
| comEvent | input | 1 | Commutation event strobe |
| trigEvent | input | 1 | Trigger event strobe |
| breakActive | input | 1 | Break input active level |
| flagVec | output | 16 | Current flag word (read data and interrupt sources) |

## Verification
The assertions assume that every event input is a single-cycle strobe sampled at the clock edge, and that the mode and control levels are stable in the cycle they qualify. The checks on overcapture and read-clear also assume that a strobe and a clear on the same bit are resolved in favour of the set. The directed tasks drive every input on the falling edge and hold it for exactly one rising edge. They then return to idle values, so each strobe is seen exactly once, and they read the flag word half a cycle later.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int FLAG_W  = 16;
  localparam int NUM_CH  = 4;
  localparam int UPD_BIT = 0;
  localparam int CC_LO   = 1;
  localparam int COM_BIT = CC_LO + NUM_CH;
  localparam int TRG_BIT = COM_BIT + 1;
  localparam int BRK_BIT = TRG_BIT + 1;
  localparam int OVC_LO  = BRK_BIT + 2;

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
  } flagStrobe_t;

  function automatic logic [FLAG_W-1:0] validMask();
    logic [FLAG_W-1:0] m;
    m = '0;
    m[UPD_BIT] = 1'b1;
    m[COM_BIT] = 1'b1;
    m[TRG_BIT] = 1'b1;
    m[BRK_BIT] = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      m[CC_LO+i]  = 1'b1;
      m[OVC_LO+i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tmr_flag_ctrl.sv
module tmr_flag_ctrl
  import tmr_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [FLAG_W-1:0] busWrData,
  input  logic [NUM_CH-1:0] ccRegRead,
  input  logic              repOvf,
  input  logic              swUpdReq,
  input  logic              trigReinit,
  input  logic              updDisable,
  input  logic              updSourceSel,
  input  logic [NUM_CH-1:0] ccEvent,
  input  logic [NUM_CH-1:0] ccInputMode,
  input  logic              comEvent,
  input  logic              trigEvent,
  input  logic              breakActive,
  input  logic [FLAG_W-1:0] flags,
  output flagStrobe_t       strobe
);
  localparam logic [FLAG_W-1:0] VALID = validMask();

  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] clrVec;
  logic              updFromRep;
  logic              updFromOther;

  assign updFromRep   = repOvf && !updDisable;
  assign updFromOther = (swUpdReq || trigReinit) && !updDisable && !updSourceSel;

  always_comb begin
    setVec          = '0;
    setVec[UPD_BIT] = updFromRep || updFromOther;
    setVec[COM_BIT] = comEvent;
    setVec[TRG_BIT] = trigEvent;
    setVec[BRK_BIT] = breakActive;
    for (int i = 0; i < NUM_CH; i++) begin
      setVec[CC_LO+i]  = ccEvent[i];
      setVec[OVC_LO+i] = ccEvent[i] && ccInputMode[i] && flags[CC_LO+i];
    end
  end

  always_comb begin
    clrVec = busWrEn ? ~busWrData : '0;
    for (int i = 0; i < NUM_CH; i++) begin
      clrVec[CC_LO+i] = clrVec[CC_LO+i] | ccRegRead[i];
    end
    clrVec = clrVec & VALID;
  end

  assign strobe.setMask = setVec & VALID;
  assign strobe.clrMask = clrVec;

  // R2: an enabled repetition update must show in the flag word next cycle
  assert_rep_update_R2: assert property (@(posedge clk) disable iff (!rstN)
    (repOvf && !updDisable) |=> flags[UPD_BIT]);

  // R8: break level forces the flag on the following cycle
  assert_break_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    breakActive |=> flags[BRK_BIT]);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChk
    // R6: a read without a simultaneous event clears the channel flag
    assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      (ccRegRead[g] && !ccEvent[g]) |=> !flags[CC_LO+g]);
    // R9: second capture in input mode raises overcapture
    assert_overcapture_R9: assert property (@(posedge clk) disable iff (!rstN)
      (ccEvent[g] && ccInputMode[g] && flags[CC_LO+g]) |=> flags[OVC_LO+g]);
    // R9: output compare mode never raises overcapture from a clear state
    assert_no_ovc_output_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!ccInputMode[g] && !flags[OVC_LO+g]) |=> !flags[OVC_LO+g]);
  end
endmodule

// File: rtl/tmr_flag_dp.sv
module tmr_flag_dp
  import tmr_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  output logic [FLAG_W-1:0] flags
);
  localparam logic [FLAG_W-1:0] VALID = validMask();

  logic [FLAG_W-1:0] flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= ((flagQ & ~strobe.clrMask) | strobe.setMask) & VALID;
  end

  assign flags = flagQ;

  // R10: every bit set this cycle is visible next cycle regardless of clears
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.setMask) |=> ((flagQ & $past(strobe.setMask)) == $past(strobe.setMask)));

  // R5: a bit with neither set nor clear keeps its value
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrMask == '0 && strobe.setMask == '0) |=> $stable(flagQ));

  // R11: reserved bits stay low
  assert_reserved_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ & ~VALID) == '0);
endmodule

// File: rtl/timer_status_flags.sv
module timer_status_flags
  import tmr_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [15:0]       busWrData,
  input  logic [3:0]        ccRegRead,
  input  logic              repOvf,
  input  logic              swUpdReq,
  input  logic              trigReinit,
  input  logic              updDisable,
  input  logic              updSourceSel,
  input  logic [3:0]        ccEvent,
  input  logic [3:0]        ccInputMode,
  input  logic              comEvent,
  input  logic              trigEvent,
  input  logic              breakActive,
  output logic [15:0]       flagVec
);
  flagStrobe_t       strobe;
  logic [FLAG_W-1:0] flags;

  tmr_flag_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .ccRegRead(ccRegRead), .repOvf(repOvf), .swUpdReq(swUpdReq),
    .trigReinit(trigReinit), .updDisable(updDisable), .updSourceSel(updSourceSel),
    .ccEvent(ccEvent), .ccInputMode(ccInputMode), .comEvent(comEvent),
    .trigEvent(trigEvent), .breakActive(breakActive), .flags(flags),
    .strobe(strobe)
  );

  tmr_flag_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flags(flags)
  );

  assign flagVec = flags;
endmodule

// File: tb/timer_status_flags_tb_top.sv
module timer_status_flags_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [3:0]  ccRegRead = '0;
  logic        repOvf = 1'b0, swUpdReq = 1'b0, trigReinit = 1'b0;
  logic        updDisable = 1'b0, updSourceSel = 1'b0;
  logic [3:0]  ccEvent = '0, ccInputMode = '0;
  logic        comEvent = 1'b0, trigEvent = 1'b0, breakActive = 1'b0;
  logic [15:0] flagVec;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  timer_status_flags dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWrData(busWrData),
    .ccRegRead(ccRegRead), .repOvf(repOvf), .swUpdReq(swUpdReq),
    .trigReinit(trigReinit), .updDisable(updDisable), .updSourceSel(updSourceSel),
    .ccEvent(ccEvent), .ccInputMode(ccInputMode), .comEvent(comEvent),
    .trigEvent(trigEvent), .breakActive(breakActive), .flagVec(flagVec)
  );

  task automatic chk(input string req, input logic [15:0] exp);
    total++;
    if (flagVec !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, flagVec, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    busWrEn = 0; ccRegRead = '0; repOvf = 0; swUpdReq = 0; trigReinit = 0;
    ccEvent = '0; comEvent = 0; trigEvent = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    busWrEn = 1; busWrData = d; step(); idle();
  endtask

  task automatic t_reset();
    chk("R1", 16'h0000);
    chk("R11", 16'h0000);
  endtask

  task automatic t_update();
    updDisable = 0; updSourceSel = 0;
    repOvf = 1; step(); idle(); chk("R2", 16'h0001);
    wr(16'hFFFE); chk("R5", 16'h0000);
    updDisable = 1; repOvf = 1; step(); idle(); chk("R2", 16'h0000);
    updDisable = 0; updSourceSel = 1; repOvf = 1; step(); idle(); chk("R2", 16'h0001);
    wr(16'h0000);
    swUpdReq = 1; step(); idle(); chk("R3", 16'h0000);
    updSourceSel = 0; swUpdReq = 1; step(); idle(); chk("R3", 16'h0001);
    wr(16'h0000);
    updDisable = 1; trigReinit = 1; step(); idle(); chk("R3", 16'h0000);
    updDisable = 0; trigReinit = 1; step(); idle(); chk("R3", 16'h0001);
    wr(16'h0000);
  endtask

  task automatic t_channel();
    ccInputMode = 4'b0001;
    ccEvent = 4'b0100; step(); idle(); chk("R4", 16'h0008);
    ccEvent = 4'b0001; step(); idle(); chk("R4", 16'h000A);
    wr(16'hFFFF); chk("R5", 16'h000A);
    ccRegRead = 4'b0100; step(); idle(); chk("R6", 16'h0002);
    wr(16'hFFFD); chk("R5", 16'h0000);
  endtask

  task automatic t_comtrig();
    comEvent = 1; trigEvent = 1; step(); idle(); chk("R7", 16'h0060);
    ccRegRead = 4'b1111; step(); idle(); chk("R7", 16'h0060);
    wr(16'hFFDF); chk("R7", 16'h0040);
    wr(16'h0000); chk("R7", 16'h0000);
  endtask

  task automatic t_break();
    breakActive = 1; step(); chk("R8", 16'h0080);
    wr(16'h0000); chk("R8", 16'h0080);
    breakActive = 0; step(); chk("R8", 16'h0080);
    wr(16'hFF7F); chk("R8", 16'h0000);
  endtask

  task automatic t_overcapture();
    ccInputMode = 4'b0010;
    ccEvent = 4'b0010; step(); idle(); chk("R9", 16'h0004);
    ccEvent = 4'b0010; step(); idle(); chk("R9", 16'h0404);
    ccRegRead = 4'b0010; step(); idle(); chk("R9", 16'h0400);
    wr(16'hFBFF); chk("R9", 16'h0000);
    ccEvent = 4'b1000; step(); idle();
    ccEvent = 4'b1000; step(); idle(); chk("R9", 16'h0010);
    wr(16'h0000);
  endtask

  task automatic t_race();
    ccEvent = 4'b0001; busWrEn = 1; busWrData = 16'h0000; step(); idle();
    chk("R10", 16'h0002);
    ccEvent = 4'b0001; ccRegRead = 4'b0001; step(); idle(); chk("R10", 16'h0002);
    comEvent = 1; busWrEn = 1; busWrData = 16'h0000; step(); idle();
    chk("R10", 16'h0020);
    wr(16'h0000);
  endtask

  task automatic t_reserved();
    ccInputMode = 4'b1111;
    ccEvent = 4'b1111; repOvf = 1; comEvent = 1; trigEvent = 1; step(); idle();
    ccEvent = 4'b1111; breakActive = 1; step(); idle(); breakActive = 0;
    chk("R11", 16'h1EFF);
    wr(16'hFFFF); chk("R11", 16'h1EFF);
    wr(16'h0000); chk("R5", 16'h0000);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_update();
    t_channel();
    t_comtrig();
    t_break();
    t_overcapture();
    t_race();
    t_reserved();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule